// File: doc/BRIEF.md
# Fused-Operation 64-bit Integer ALU

This block is the integer execution datapath of a 64-bit core. Each cycle it takes two 64-bit operands and a 7-bit operation code, and it returns a 64-bit result and a branch-taken flag. It covers the usual shift, add, subtract, compare and logic operations. It also covers single-bit manipulation, shift-then-add, and 32-bit word forms whose results are sign-extended. A set of fused forms joins an addition with a right shift, a narrowing, or an immediate merge, so that common two-instruction idioms finish in a single operation.

The upper three bits of the code select an operation group, and the lower four bits select the operation within that group. When the parameter `REG_OUT` is 1 (the default), the result and the flag pass through one output register. Reset is synchronous and active-high.

Top module: `fused_alu`

## Requirements
- R1: Group bits op[6:4] decode as 000 shift/bit, 001 word, 010 add, 011 subtract/compare, 100 logic, 110 narrowed logic, 111 branch compare. Every code not listed in R2 to R13, including all of group 101, gives result 0 and flag 0.
- R2: Shifts use src2[5:0] as the amount. 0x01 shifts left, 0x05 shifts right logically, 0x07 shifts right arithmetically, and 0x00 shifts left the zero-extended src1[31:0].
- R3: With idx = src2[5:0], 0x02 clears bit idx of src1, 0x03 sets it, 0x04 inverts it, and 0x06 returns (src1 >> idx) & 1.
- R4: 0x09 rotates src1 left by src2[5:0] across 64 bits, and 0x0B rotates it right.
- R5: 0x21 gives src1+src2, and 0x20 gives zext(src1[31:0])+src2. 0x29/0x2B/0x2D/0x2F give (src1<<1/2/3/4)+src2. 0x28/0x2A/0x2C give (zext(src1[31:0])<<1/2/3)+src2.
- R6: 0x24, 0x25, 0x26 and 0x27 give (src1 >> K)+src2 with a logical shift of K = 29, 30, 31 and 32.
- R7: 0x22 gives src1[0]+src2. 0x23 gives sext(src2[11:0]) + (src2 with bits [11:0] cleared).
- R8: Word forms work on the low 32 bits, and their 32-bit results are sign-extended to 64 bits. 0x10 adds, 0x11 gives src1[0]+src2, 0x12 subtracts, and 0x13 is the word form of the R7 merge. 0x18, 0x19 and 0x1A shift left, right logically and right arithmetically by src2[4:0]. 0x1C and 0x1D rotate left and right across 32 bits by src2[4:0].
- R9: With s = src1[31:0]+src2[31:0], 0x14 returns s[0], 0x15 returns zext(s[7:0]), 0x16 returns zext(s[15:0]), and 0x17 returns sext(s[15:0]).
- R10: 0x30 gives src1-src2. 0x31 and 0x32 give 1 when src1<src2 (unsigned and signed) and 0 otherwise. 0x34/0x35 give the unsigned max/min, and 0x36/0x37 give the signed max/min.
- R11: 0x40 and, 0x41 src1&~src2, 0x42 or, 0x43 src1|~src2, 0x44 xor, 0x45 xnor. 0x46 sets each byte of src1 to 0xFF if that byte is non-zero and to 0x00 otherwise.
- R12: Code {110, p[3:1], m} takes the plain logic result of code {100, p[3:1], 0}. When m=0 it returns only bit 0 of that result. When m=1 it returns the low 16 bits, zero-extended.
- R13: Codes 0x70, 0x72, 0x78, 0x7A, 0x7C and 0x7E set the flag for equal, not-equal, signed less, signed greater-or-equal, unsigned less and unsigned greater-or-equal. Their result is 0, and every other code leaves the flag at 0.
- R14: With REG_OUT=1, the result and flag appear one clock after the inputs are sampled. A cycle with rst high leaves both outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 7 | Operation code, group in [6:4] |
| src1 | input | 64 | First operand |
| src2 | input | 64 | Second operand, also amount/index/immediate source |
| res | output | 64 | Result |
| taken | output | 1 | Branch-taken flag |

## Verification
The bench drives all 128 codes against operands chosen to expose corner cases. Shift amounts of 0, 31, 32 and 63 catch a rotate that drops bits or a word shift that reads bit 5 of the amount. Operands where bit 31 or bit 11 is set catch a missing sign extension on a word result or a merged immediate. The same patterns catch a right-shift-add that shifts arithmetically instead of logically. Equal and sign-opposite operands show a compare that mixes up signed and unsigned order or picks the wrong min/max operand. Sweeping the unused codes and group 101 exposes a decoder that aliases them onto real operations.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int ALU_OP_W = 7;
  localparam int IMM_W    = 12;
  localparam int SR_BASE  = 29;
  localparam int HW_W     = 16;
  localparam int BYTE_W   = 8;

  typedef enum logic [2:0] {
    GRP_SHIFT  = 3'b000,
    GRP_WORD   = 3'b001,
    GRP_ADD    = 3'b010,
    GRP_CMP    = 3'b011,
    GRP_LOGIC  = 3'b100,
    GRP_RSV    = 3'b101,
    GRP_NARROW = 3'b110,
    GRP_BRANCH = 3'b111
  } alu_grp_e;
endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic [3:0]      fn,
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  sh,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] bit_mask;
  logic [XLEN-1:0] srl_v;
  logic [XLEN-1:0] rol_v;
  logic [XLEN-1:0] ror_v;
  logic [XLEN-1:0] low_zx;

  assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << sh;
  assign srl_v    = a >> sh;
  assign low_zx   = {{(XLEN-HALF){1'b0}}, a[HALF-1:0]};
  assign rol_v    = XLEN'(({a, a} << sh) >> XLEN);
  assign ror_v    = XLEN'({a, a} >> sh);

  always_comb begin
    case (fn)
      4'h0:    res = low_zx << sh;
      4'h1:    res = a << sh;
      4'h2:    res = a & ~bit_mask;
      4'h3:    res = a | bit_mask;
      4'h4:    res = a ^ bit_mask;
      4'h5:    res = srl_v;
      4'h6:    res = XLEN'(srl_v[0]);
      4'h7:    res = XLEN'($signed(a) >>> sh);
      4'h9:    res = rol_v;
      4'hB:    res = ror_v;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_word_unit.sv
module alu_word_unit
  import alu_pkg::*;
#(
  parameter int HALF = 32,
  localparam int XLEN = 2 * HALF,
  localparam int WSH = $clog2(HALF)
) (
  input  logic [3:0]      fn,
  input  logic [HALF-1:0] a,
  input  logic [HALF-1:0] b,
  output logic [XLEN-1:0] res
);
  logic [WSH-1:0]  amt;
  logic [HALF-1:0] sum_w, odd_w, dif_w, imm_w, sll_w, srl_w, sra_w, rol_w, ror_w;

  function automatic logic [XLEN-1:0] sx(input logic [HALF-1:0] v);
    return {{(XLEN-HALF){v[HALF-1]}}, v};
  endfunction

  assign amt   = b[WSH-1:0];
  assign sum_w = a + b;
  assign odd_w = b + {{(HALF-1){1'b0}}, a[0]};
  assign dif_w = a - b;
  assign imm_w = {b[HALF-1:IMM_W], {IMM_W{1'b0}}} + {{(HALF-IMM_W){b[IMM_W-1]}}, b[IMM_W-1:0]};
  assign sll_w = a << amt;
  assign srl_w = a >> amt;
  assign sra_w = HALF'($signed(a) >>> amt);
  assign rol_w = HALF'(({a, a} << amt) >> HALF);
  assign ror_w = HALF'({a, a} >> amt);

  always_comb begin
    case (fn)
      4'h0:    res = sx(sum_w);
      4'h1:    res = sx(odd_w);
      4'h2:    res = sx(dif_w);
      4'h3:    res = sx(imm_w);
      4'h4:    res = XLEN'(sum_w[0]);
      4'h5:    res = XLEN'(sum_w[BYTE_W-1:0]);
      4'h6:    res = XLEN'(sum_w[HW_W-1:0]);
      4'h7:    res = {{(XLEN-HW_W){sum_w[HW_W-1]}}, sum_w[HW_W-1:0]};
      4'h8:    res = sx(sll_w);
      4'h9:    res = sx(srl_w);
      4'hA:    res = sx(sra_w);
      4'hC:    res = sx(rol_w);
      4'hD:    res = sx(ror_w);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  alu_grp_e        grp,
  input  logic [3:0]      fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            taken
);
  logic [XLEN-1:0] low_zx, imm_mrg, sr_sum, shadd_sum, diff;
  logic [SHW-1:0]  sr_amt;
  logic [2:0]      pre_sh;
  logic            ltu, lts, eq;

  assign low_zx  = {{(XLEN-HALF){1'b0}}, a[HALF-1:0]};
  assign imm_mrg = {b[XLEN-1:IMM_W], {IMM_W{1'b0}}} + {{(XLEN-IMM_W){b[IMM_W-1]}}, b[IMM_W-1:0]};
  assign sr_amt  = SHW'(SR_BASE) + SHW'(fn[1:0]);
  assign sr_sum  = (a >> sr_amt) + b;
  assign pre_sh  = {1'b0, fn[2:1]} + 3'd1;
  assign shadd_sum = ((fn[0] ? a : low_zx) << pre_sh) + b;
  assign diff    = a - b;
  assign ltu     = a < b;
  assign lts     = $signed(a) < $signed(b);
  assign eq      = a == b;

  always_comb begin
    res   = '0;
    taken = 1'b0;
    case (grp)
      GRP_ADD: begin
        case (fn)
          4'h0:                   res = low_zx + b;
          4'h1:                   res = a + b;
          4'h2:                   res = b + XLEN'(a[0]);
          4'h3:                   res = imm_mrg;
          4'h4, 4'h5, 4'h6, 4'h7: res = sr_sum;
          4'hE:                   res = '0;
          default:                res = shadd_sum;
        endcase
      end
      GRP_CMP: begin
        case (fn)
          4'h0:    res = diff;
          4'h1:    res = XLEN'(ltu);
          4'h2:    res = XLEN'(lts);
          4'h4:    res = ltu ? b : a;
          4'h5:    res = ltu ? a : b;
          4'h6:    res = lts ? b : a;
          4'h7:    res = lts ? a : b;
          default: res = '0;
        endcase
      end
      GRP_BRANCH: begin
        case (fn)
          4'h0:    taken = eq;
          4'h2:    taken = !eq;
          4'h8:    taken = lts;
          4'hA:    taken = !lts;
          4'hC:    taken = ltu;
          4'hE:    taken = !ltu;
          default: taken = 1'b0;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int NBYTES = XLEN / BYTE_W
) (
  input  logic [3:0]      fn,
  input  logic            narrow,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  logic [3:0]      plain_fn;
  logic [XLEN-1:0] byte_or;
  logic [XLEN-1:0] plain;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign byte_or[g*BYTE_W +: BYTE_W] = {BYTE_W{|a[g*BYTE_W +: BYTE_W]}};
  end

  // narrowed codes reuse the plain decode with the low bit forced to zero
  assign plain_fn = narrow ? {fn[3:1], 1'b0} : fn;

  always_comb begin
    case (plain_fn)
      4'h0:    plain = a & b;
      4'h1:    plain = a & ~b;
      4'h2:    plain = a | b;
      4'h3:    plain = a | ~b;
      4'h4:    plain = a ^ b;
      4'h5:    plain = ~(a ^ b);
      4'h6:    plain = byte_or;
      default: plain = '0;
    endcase
  end

  always_comb begin
    if (!narrow)     res = plain;
    else if (fn[0])  res = XLEN'(plain[HW_W-1:0]);
    else             res = XLEN'(plain[0]);
  end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import alu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int SHW  = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ALU_OP_W-1:0] op,
  input  logic [XLEN-1:0]     src1,
  input  logic [XLEN-1:0]     src2,
  output logic [XLEN-1:0]     res,
  output logic                taken
);
  alu_grp_e        grp;
  logic [3:0]      fn;
  logic [XLEN-1:0] shift_res, word_res, arith_res, logic_res, res_c;
  logic            taken_c;

  assign grp = alu_grp_e'(op[6:4]);
  assign fn  = op[3:0];

  alu_shift_unit #(.XLEN(XLEN)) u_shift (
    .fn(fn), .a(src1), .sh(src2[SHW-1:0]), .res(shift_res)
  );

  alu_word_unit #(.HALF(HALF)) u_word (
    .fn(fn), .a(src1[HALF-1:0]), .b(src2[HALF-1:0]), .res(word_res)
  );

  alu_arith_unit #(.XLEN(XLEN)) u_arith (
    .grp(grp), .fn(fn), .a(src1), .b(src2), .res(arith_res), .taken(taken_c)
  );

  alu_logic_unit #(.XLEN(XLEN)) u_logic (
    .fn(fn), .narrow(grp == GRP_NARROW), .a(src1), .b(src2), .res(logic_res)
  );

  always_comb begin
    case (grp)
      GRP_SHIFT:             res_c = shift_res;
      GRP_WORD:              res_c = word_res;
      GRP_ADD, GRP_CMP:      res_c = arith_res;
      GRP_LOGIC, GRP_NARROW: res_c = logic_res;
      default:               res_c = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res   <= '0;
        taken <= 1'b0;
      end else begin
        res   <= res_c;
        taken <= taken_c;
      end
    end

    a_r14_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (res == '0 && !taken));

    a_r13_branch_no_data: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op[6:4]) == 3'b111) |-> res == '0);

    a_r13_flag_branch_only: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op[6:4]) != 3'b111) |-> !taken);

    a_r1_reserved_group: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op[6:4]) == 3'b101) |-> (res == '0 && !taken));

    a_r12_lsb_only: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op[6:4]) == 3'b110 && !$past(op[0])) |-> res[XLEN-1:1] == '0);

    a_r12_half_zext: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op[6:4]) == 3'b110 && $past(op[0])) |-> res[XLEN-1:HW_W] == '0);

    a_r8_word_sext: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op[6:4]) == 3'b001 && $past(op[3:2]) != 2'b01)
      |-> res[XLEN-1:HALF] == {HALF{res[HALF-1]}});
  end else begin : g_comb
    assign res   = res_c;
    assign taken = taken_c;
  end
endmodule

// File: tb/tb_fused_alu.sv
`timescale 1ns/1ps
module tb_fused_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  op = '0;
  logic [63:0] src1 = '0, src2 = '0;
  logic [63:0] res;
  logic        taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        pend = 0;
  logic [6:0]  pend_op;
  logic [65:0] pend_exp;

  always #2.5 clk = ~clk;

  fused_alu dut (.clk(clk), .rst(rst), .op(op), .src1(src1), .src2(src2), .res(res), .taken(taken));

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] orc(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = (v[i*8 +: 8] != 0) ? 8'hFF : 8'h00;
    return r;
  endfunction

  // returns {listed, taken, result}
  function automatic logic [65:0] ref_alu(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r, p;
    logic [31:0] w;
    logic t, listed;
    int s, ws;
    s = int'(b[5:0]);
    ws = int'(b[4:0]);
    r = '0; t = 0; listed = 1;
    w = a[31:0] + b[31:0];
    case (o)
      7'h00: r = {32'h0, a[31:0]} << s;
      7'h01: r = a << s;
      7'h02: r = a & ~(64'd1 << s);
      7'h03: r = a | (64'd1 << s);
      7'h04: r = a ^ (64'd1 << s);
      7'h05: r = a >> s;
      7'h06: r = {63'd0, a[s]};
      7'h07: r = $signed(a) >>> s;
      7'h09: r = (s == 0) ? a : ((a << s) | (a >> (64 - s)));
      7'h0B: r = (s == 0) ? a : ((a >> s) | (a << (64 - s)));
      7'h10: r = sx32(w);
      7'h11: r = sx32(b[31:0] + {31'd0, a[0]});
      7'h12: r = sx32(a[31:0] - b[31:0]);
      7'h13: r = sx32({b[31:12], 12'h0} + {{20{b[11]}}, b[11:0]});
      7'h14: r = {63'd0, w[0]};
      7'h15: r = {56'd0, w[7:0]};
      7'h16: r = {48'd0, w[15:0]};
      7'h17: r = {{48{w[15]}}, w[15:0]};
      7'h18: r = sx32(a[31:0] << ws);
      7'h19: r = sx32(a[31:0] >> ws);
      7'h1A: r = sx32($signed(a[31:0]) >>> ws);
      7'h1C: r = sx32((ws == 0) ? a[31:0] : ((a[31:0] << ws) | (a[31:0] >> (32 - ws))));
      7'h1D: r = sx32((ws == 0) ? a[31:0] : ((a[31:0] >> ws) | (a[31:0] << (32 - ws))));
      7'h20: r = {32'h0, a[31:0]} + b;
      7'h21: r = a + b;
      7'h22: r = b + {63'd0, a[0]};
      7'h23: r = {b[63:12], 12'h0} + {{52{b[11]}}, b[11:0]};
      7'h24: r = (a >> 29) + b;
      7'h25: r = (a >> 30) + b;
      7'h26: r = (a >> 31) + b;
      7'h27: r = (a >> 32) + b;
      7'h28: r = ({32'h0, a[31:0]} << 1) + b;
      7'h29: r = (a << 1) + b;
      7'h2A: r = ({32'h0, a[31:0]} << 2) + b;
      7'h2B: r = (a << 2) + b;
      7'h2C: r = ({32'h0, a[31:0]} << 3) + b;
      7'h2D: r = (a << 3) + b;
      7'h2F: r = (a << 4) + b;
      7'h30: r = a - b;
      7'h31: r = {63'd0, a < b};
      7'h32: r = {63'd0, $signed(a) < $signed(b)};
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a > b) ? b : a;
      7'h36: r = ($signed(a) > $signed(b)) ? a : b;
      7'h37: r = ($signed(a) > $signed(b)) ? b : a;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = ~(a ^ b);
      7'h46: r = orc(a);
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        case (o[2:1])
          2'd0: p = a & b;
          2'd1: p = a | b;
          2'd2: p = a ^ b;
          default: p = orc(a);
        endcase
        r = o[0] ? {48'd0, p[15:0]} : {63'd0, p[0]};
      end
      7'h70: t = (a == b);
      7'h72: t = (a != b);
      7'h78: t = $signed(a) < $signed(b);
      7'h7A: t = $signed(a) >= $signed(b);
      7'h7C: t = a < b;
      7'h7E: t = a >= b;
      default: listed = 0;
    endcase
    return {listed, t, r};
  endfunction

  function automatic string req_of(input logic [6:0] o, input logic listed);
    logic [3:0] f;
    f = o[3:0];
    if (!listed) return "R1";
    case (o[6:4])
      3'b000: return (f == 2 || f == 3 || f == 4 || f == 6) ? "R3" : ((f == 9 || f == 11) ? "R4" : "R2");
      3'b001: return (f >= 4 && f <= 7) ? "R9" : "R8";
      3'b010: return (f == 2 || f == 3) ? "R7" : ((f >= 4 && f <= 7) ? "R6" : "R5");
      3'b011: return "R10";
      3'b100: return "R11";
      3'b110: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check_pending();
    checks++;
    if (res !== pend_exp[63:0] || taken !== pend_exp[64]) begin
      fails++;
      $display("FAIL %s op=%h a=%h b=%h: res=%h taken=%b expected res=%h taken=%b",
               req_of(pend_op, pend_exp[65]), pend_op, src1, src2, res, taken, pend_exp[63:0], pend_exp[64]);
    end
    pend = 0;
  endtask

  task automatic step(input logic [6:0] o, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    if (pend) check_pending();
    op = o; src1 = x; src2 = y;
    pend_op = o;
    pend_exp = ref_alu(o, x, y);
    pend = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check_pending();
  endtask

  task automatic check_zero_r14(input string what);
    checks++;
    if (res !== 64'd0 || taken !== 1'b0) begin
      fails++;
      $display("FAIL R14 %s: res=%h taken=%b expected res=0 taken=0", what, res, taken);
    end
  endtask

  logic [63:0] ca [8];
  logic [63:0] cb [8];

  initial begin
    void'($urandom(32'h1F2E3D4C));
    ca[0] = 64'h0;                cb[0] = 64'h0;
    ca[1] = '1;                   cb[1] = '1;
    ca[2] = 64'h8000000000000000; cb[2] = 64'h1;
    ca[3] = 64'h1;                cb[3] = 64'h800000000000003F;
    ca[4] = 64'h7FFFFFFFFFFFFFFF; cb[4] = '1;
    ca[5] = 64'hFFFFFFFF80000000; cb[5] = 64'h00000000FFFFF820;
    ca[6] = 64'h123456789ABCDEF0; cb[6] = 64'h000000000000001F;
    ca[7] = 64'h80000000E0000800; cb[7] = 64'h8000000012345FFF;

    // R14: held in reset with live inputs, outputs stay zero
    op = 7'h21; src1 = 64'd5; src2 = 64'd7;
    repeat (3) @(negedge clk);
    check_zero_r14("during reset");
    rst = 0;

    for (int c = 0; c < 128; c++) begin
      for (int k = 0; k < 8; k++) step(7'(c), ca[k], cb[k]);
      for (int k = 0; k < 12; k++) step(7'(c), {$urandom, $urandom}, {$urandom, $urandom});
    end
    flush();

    // R14: reset mid-run clears a non-zero registered result
    step(7'h21, 64'd100, 64'd23);
    flush();
    @(negedge clk);
    rst = 1; op = 7'h70; src1 = 64'd9; src2 = 64'd9;
    @(negedge clk);
    check_zero_r14("after mid-run reset");
    rst = 0;
    // R13 after reset: equal operands set the flag one cycle later
    step(7'h70, 64'd9, 64'd9);
    flush();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule